// File: doc/BRIEF.md
# Word-Wide Bus ROM Slave with Strapped Wait States

This block answers read cycles on a 16-bit asynchronous processor bus whose strobes are active low. Every rising clock edge it samples the address strobe, the read strobe and the upper address bits. When a read falls inside the board's address window and maps to a fitted device pair, it pulls its active-low board-select. That select does three things: it enables a banked chip-enable decoder, it turns on the output driver for the data bus, and it lets a data-transfer acknowledge return to the processor.

The acknowledge is held back by a strap input set to suit the slowest memory part. The strap gives a wait of 0 to 4 clocks, and any larger code is treated as 4. Storage is a set of device pairs, each pair made of two byte-wide parts. One part supplies the low byte and the other the high byte, so a whole word reaches the bus in one access. The bus is word-addressed, so device addressing starts at address bit 1.

The density parameter sets how many address bits go to the devices and which bits above them feed the chip-enable decode. The bus is not a stream. Its handshake is the strobe/acknowledge pair: the master holds the address strobe low with a stable address until it sees the acknowledge, and the acknowledge is released after the strobe rises. There is no other form of back-pressure.

Top module: `bus_rom_slave`

## Requirements
- R1: While reset is asserted and right after it, sel_n and dtack_n are 1, every ce_n bit is 1, data_drv is 0 and data_o is 0.
- R2: sel_n goes to 0 after a rising edge that samples all four of these conditions: as_n=0, rd_n=0, bus_addr[23:22]==2'b10, and the pair index bus_addr[21:16] is below 20. After any other edge sel_n is 1.
- R3: dtack_n is 0 only while sel_n is 0. It first goes low N clocks after sel_n falls, where N is the wait strap value, so dtack_n is first sampled low N+1 edges after the strobe edge. It then stays low until the strobe is released.
- R4: While selected, exactly one ce_n bit is 0, the bit whose number equals the pair index. While not selected, all ce_n bits are 1.
- R5: While selected, data_o holds the selected pair's word at device address w = bus_addr[15:1]. The low byte is w[7:0] ^ {idx[4:0],3'b011}. The high byte is {1'b0,w[14:8]} ^ {3'b101,idx[4:0]}.
- R6: data_drv is 1 exactly while sel_n is 0. When data_drv is 0, data_o is 0.
- R7: A cycle with rd_n=1 (a write) is ignored: there is no select, no chip enable, no drive and no acknowledge.
- R8: After an edge that samples as_n=1, dtack_n and sel_n are 1. The wait count restarts, so a read that follows straight after waits the full strap delay again.
- R9: Strap values 5 to 7 behave exactly like 4.
- R10: A read outside the window, or one whose pair index is 20 or more, gives no select, no chip enable, no data drive and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| bus_addr | input | 23 | Word address bits 23 down to 1 |
| wait_sel | input | 3 | Static wait-state strap |
| sel_n | output | 1 | Board-select, active low |
| dtack_n | output | 1 | Data-transfer acknowledge, active low |
| ce_n | output | 20 | Per-pair chip enables, active low |
| data_o | output | 16 | Word for the external tri-state data pads |
| data_drv | output | 1 | Output enable for the data pads |

## Verification
A stuck or mis-cleared wait counter shows up at dtack_n: the next read's acknowledge comes too early or too late, counted in edges from the strobe. A stale or wrong registered pair index shows up on the first cycle after select, because the wrong ce_n bit falls and data_o carries another pair's pattern. A select that fails to clear is caught one edge after the strobe rises, because sel_n, dtack_n and data_drv are checked there.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef logic [2:0] wait_t;

  function automatic wait_t clamp_wait(input wait_t w, input wait_t lim);
    return (w > lim) ? lim : w;
  endfunction
endpackage

// File: rtl/brs_addr_match.sv
module brs_addr_match #(
  parameter int ADDR_HI   = 23,
  parameter int DEV_AW    = 15,
  parameter int SEL_W     = 6,
  parameter int NUM_PAIRS = 20,
  parameter logic [ADDR_HI-DEV_AW-SEL_W-1:0] WIN_TAG = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_n,
  input  logic             rd_n,
  input  logic [ADDR_HI:1] bus_addr,
  output logic             sel,
  output logic [SEL_W-1:0] idx_q
);
  localparam int SEL_LSB = 1 + DEV_AW;
  localparam int WIN_LSB = SEL_LSB + SEL_W;

  logic [SEL_W-1:0] idx_now;
  logic             win_hit, idx_ok, hit;

  assign idx_now = bus_addr[WIN_LSB-1:SEL_LSB];
  assign win_hit = (bus_addr[ADDR_HI:WIN_LSB] == WIN_TAG);
  assign idx_ok  = ({1'b0, idx_now} < (SEL_W+1)'(NUM_PAIRS));
  assign hit     = !as_n && !rd_n && win_hit && idx_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel   <= 1'b0;
      idx_q <= '0;
    end else begin
      sel   <= hit;
      idx_q <= idx_now;
    end
  end

  assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> ({1'b0, idx_q} < (SEL_W+1)'(NUM_PAIRS)));
  assert_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |=> !sel);
endmodule

// File: rtl/brs_ce_decode.sv
module brs_ce_decode #(
  parameter int SEL_W     = 6,
  parameter int NUM_PAIRS = 20
) (
  input  logic                 en,
  input  logic [SEL_W-1:0]     idx,
  output logic [NUM_PAIRS-1:0] ce_n
);
  localparam int NB = (NUM_PAIRS + 7) / 8;

  logic [NB-1:0] bank_en;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_en[b] = en && (idx[SEL_W-1:3] == (SEL_W-3)'(b));
    for (genvar j = 0; j < 8; j++) begin : g_line
      if (b*8 + j < NUM_PAIRS) begin : g_fit
        assign ce_n[b*8+j] = !(bank_en[b] && (idx[2:0] == 3'(j)));
      end
    end
  end

  always_comb begin
    assert_ce_onehot_R4: assert ($onehot0(~ce_n));
    if (!en) assert_ce_idle_R4: assert (&ce_n);
  end
endmodule

// File: rtl/brs_ack_delay.sv
module brs_ack_delay
  import brs_pkg::*;
#(
  parameter int MAX_WAIT = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  active,
  input  wait_t wait_cfg,
  output logic  ack
);
  localparam wait_t MAXW = wait_t'(MAX_WAIT);

  wait_t cnt, wait_eff;

  assign wait_eff = clamp_wait(wait_cfg, MAXW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!active)       cnt <= '0;
    else if (cnt != MAXW)   cnt <= cnt + 1'b1;
  end

  assign ack = active && (cnt >= wait_eff);

  assert_cnt_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= MAXW);
  assert_cnt_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
  assert_ack_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ack && $stable(wait_cfg)) |=> (!active || ack));
endmodule

// File: rtl/brs_rom_pair.sv
module brs_byte_dev #(
  parameter int DEV_AW = 15,
  parameter int IDX    = 0,
  parameter int HALF   = 0
) (
  input  logic              ce_n,
  input  logic [DEV_AW-1:0] dev_addr,
  output logic [7:0]        q
);
  localparam logic [4:0] ID5 = 5'(IDX);

  logic [15:0] w16;
  logic [7:0]  content;

  assign w16 = 16'(dev_addr);

  if (HALF == 0) begin : g_lo
    assign content = w16[7:0] ^ {ID5, 3'b011};
  end else begin : g_hi
    assign content = w16[15:8] ^ {3'b101, ID5};
  end

  assign q = ce_n ? 8'h00 : content;
endmodule

module brs_rom_pair #(
  parameter int DEV_AW = 15,
  parameter int IDX    = 0
) (
  input  logic              ce_n,
  input  logic [DEV_AW-1:0] dev_addr,
  output logic [15:0]       word
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    brs_byte_dev #(.DEV_AW(DEV_AW), .IDX(IDX), .HALF(h)) u_dev (
      .ce_n     (ce_n),
      .dev_addr (dev_addr),
      .q        (word[h*8 +: 8])
    );
  end
endmodule

// File: rtl/bus_rom_slave.sv
module bus_rom_slave
  import brs_pkg::*;
#(
  parameter int ADDR_HI   = 23,
  parameter int DEV_AW    = 15,
  parameter int SEL_W     = 6,
  parameter int NUM_PAIRS = 20,
  parameter int MAX_WAIT  = 4,
  parameter logic [ADDR_HI-DEV_AW-SEL_W-1:0] WIN_TAG = 2'b10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 as_n,
  input  logic                 rd_n,
  input  logic [ADDR_HI:1]     bus_addr,
  input  logic [2:0]           wait_sel,
  output logic                 sel_n,
  output logic                 dtack_n,
  output logic [NUM_PAIRS-1:0] ce_n,
  output logic [15:0]          data_o,
  output logic                 data_drv
);
  logic             sel, ack;
  logic [SEL_W-1:0] idx_q;
  logic [15:0]      pair_word [NUM_PAIRS];
  logic [15:0]      merged;

  brs_addr_match #(
    .ADDR_HI(ADDR_HI), .DEV_AW(DEV_AW), .SEL_W(SEL_W),
    .NUM_PAIRS(NUM_PAIRS), .WIN_TAG(WIN_TAG)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .rd_n(rd_n),
    .bus_addr(bus_addr), .sel(sel), .idx_q(idx_q)
  );

  brs_ce_decode #(.SEL_W(SEL_W), .NUM_PAIRS(NUM_PAIRS)) u_dec (
    .en(sel), .idx(idx_q), .ce_n(ce_n)
  );

  brs_ack_delay #(.MAX_WAIT(MAX_WAIT)) u_wait (
    .clk(clk), .rst_n(rst_n), .active(sel), .wait_cfg(wait_sel), .ack(ack)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    brs_rom_pair #(.DEV_AW(DEV_AW), .IDX(p)) u_pair (
      .ce_n(ce_n[p]), .dev_addr(bus_addr[DEV_AW:1]), .word(pair_word[p])
    );
  end

  always_comb begin
    merged = '0;
    for (int p = 0; p < NUM_PAIRS; p++) merged |= pair_word[p];
  end

  assign sel_n    = !sel;
  assign dtack_n  = !ack;
  assign data_drv = sel;
  assign data_o   = sel ? merged : 16'h0000;

  assert_ack_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> !sel_n);
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (dtack_n && sel_n));
  assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !data_drv |-> (data_o == 16'h0000));
  assert_ce_follows_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> ($countones(~ce_n) == 1));
endmodule

// File: tb/bus_rom_slave_test.sv
`timescale 1ns/1ps
module bus_rom_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        as_n = 1'b1, rd_n = 1'b1;
  logic [23:1] bus_addr = '0;
  logic [2:0]  wait_sel = '0;
  logic        sel_n, dtack_n, data_drv;
  logic [19:0] ce_n;
  logic [15:0] data_o;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  bus_rom_slave uut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .rd_n(rd_n), .bus_addr(bus_addr),
    .wait_sel(wait_sel), .sel_n(sel_n), .dtack_n(dtack_n), .ce_n(ce_n),
    .data_o(data_o), .data_drv(data_drv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [23:1] a);
    logic [4:0]  id = a[20:16];
    logic [14:0] w  = a[15:1];
    return {({1'b0, w[14:8]} ^ {3'b101, id}), (w[7:0] ^ {id, 3'b011})};
  endfunction

  function automatic bit is_hit(input logic [23:1] a, input bit rd);
    return rd && (a[23:22] == 2'b10) && (a[21:16] < 6'd20);
  endfunction

  task automatic bus_cycle(input logic [23:1] a, input logic [2:0] ws, input bit rd);
    int  first = 0;
    int  n = (ws > 3'd4) ? 4 : int'(ws);
    bit  hit = is_hit(a, rd);
    @(negedge clk);
    bus_addr = a; wait_sel = ws; rd_n = !rd; as_n = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk("R2 select", {31'b0, sel_n}, {31'b0, !hit});
        chk("R6 drive", {31'b0, data_drv}, {31'b0, hit});
        if (hit) begin
          chk("R4 chip enable", {12'b0, ce_n}, {12'b0, ~(20'b1 << a[21:16])});
          chk("R5 data word", {16'b0, data_o}, {16'b0, exp_word(a)});
        end else begin
          chk("R10 no enables", {12'b0, ce_n}, {12'b0, 20'hFFFFF});
          chk("R10 no data", {16'b0, data_o}, 32'h0);
        end
      end
      if (!dtack_n && first == 0) first = k;
    end
    if (hit) begin
      chk(ws > 3'd4 ? "R9 clamped wait" : "R3 wait clocks", first, n + 1);
      chk("R3 ack held", {31'b0, dtack_n}, 32'h0);
    end else begin
      chk(rd ? "R10 no ack" : "R7 write no ack", first, 0);
    end
    as_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk("R8 ack released", {31'b0, dtack_n}, 32'h1);
    chk("R8 select released", {31'b0, sel_n}, 32'h1);
    chk("R6 drive off", {15'b0, data_drv, data_o}, 32'h0);
  endtask

  initial begin
    #20000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:1] a;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {26'b0, sel_n, dtack_n, data_drv, &ce_n, |data_o, 1'b0}, {26'b0, 6'b110100});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {28'b0, sel_n, dtack_n, data_drv, &ce_n}, 32'b1101);
    for (int ws = 0; ws < 8; ws++)
      bus_cycle({2'b10, 6'(ws * 2), 15'h1234 + 15'(ws)}, 3'(ws), 1'b1);
    for (int p = 0; p < 20; p++)
      bus_cycle({2'b10, 6'(p), 15'(p * 1777)}, 3'd2, 1'b1);
    bus_cycle({2'b10, 6'd19, 15'h7FFF}, 3'd0, 1'b1);
    bus_cycle({2'b10, 6'd0, 15'h0000}, 3'd4, 1'b1);
    bus_cycle({2'b10, 6'd20, 15'h0100}, 3'd0, 1'b1);
    bus_cycle({2'b10, 6'd63, 15'h0100}, 3'd1, 1'b1);
    bus_cycle({2'b01, 6'd3, 15'h0100}, 3'd0, 1'b1);
    bus_cycle({2'b11, 6'd3, 15'h0100}, 3'd0, 1'b1);
    bus_cycle({2'b10, 6'd5, 15'h0100}, 3'd0, 1'b0);
    bus_cycle({2'b10, 6'd5, 15'h0100}, 3'd4, 1'b1);
    bus_cycle({2'b10, 6'd5, 15'h0100}, 3'd4, 1'b1);
    for (int i = 0; i < 300; i++) begin
      a = 23'($urandom);
      if ($urandom_range(0, 99) < 80) begin
        a[23:22] = 2'b10;
        a[21:16] = 6'($urandom_range(0, 19));
      end
      bus_cycle(a, 3'($urandom_range(0, 7)), $urandom_range(0, 9) != 0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule